// File: doc/BRIEF.md
# 100BASE-TX Transmit Line Encoder

This block turns the nibble stream of a media-independent transmit interface into a three-level line signal. A frame is marked by a transmit enable. The block frames the nibbles with start and end delimiters and fills the gaps with idle. It maps every nibble to a five-bit code group and sends the code groups out one bit per clock. Each bit is whitened with a free-running scrambler. The resulting stream passes through an NRZI stage and then an MLT-3 stage, which gives a signed two-bit level for the line driver.

The block runs on one clock that stands for the bit clock. An internal divide-by-five strobe marks the clock edges where a new nibble is taken. Upstream logic presents `tx_en_i` and `txd_i` while `nib_stb_o` is high, and the block takes them on that edge.

Top module: `fe_tx_encoder`

## Requirements
- R1: `nib_stb_o` is high in exactly one clock of every five. It is high during the first clock after reset is released.
- R2: On a strobe edge in the data phase with `tx_en_i` high, the nibble is coded as follows, given as hex nibble to code group with the leftmost bit first: 0→11110, 1→01001, 2→10100, 3→10101, 4→01010, 5→01011, 6→01110, 7→01111, 8→10010, 9→10011, A→10110, B→10111, C→11010, D→11011, E→11100, F→11101.
- R3: A strobe edge in the idle phase with `tx_en_i` high starts a frame. The group 11000 is sent, and the group 10001 is always sent at the next strobe. The nibbles presented at these two strobes are dropped, and the data phase follows.
- R4: A strobe edge in the data phase with `tx_en_i` low sends 01101. The next strobe sends 00111, whatever `tx_en_i` is at that strobe. The block then returns to the idle phase.
- R5: Each strobe edge in the idle phase with `tx_en_i` low sends the idle group 11111.
- R6: A group is loaded on its strobe edge. Its five bits are consumed on the five edges that follow, leftmost bit first.
- R7: Every clock edge steps an 11-bit scrambler state s, which is all ones at reset. The key is k = s[10] XOR s[8]. The state moves to {s[9:0], k}, and the line bit is the code bit XOR k.
- R8: The NRZI level toggles on a line bit of 1 and holds on a line bit of 0.
- R9: `mlt_o` steps one place along the cycle 0, +1, 0, −1 for each NRZI toggle and holds otherwise. The encoding is 2'b00 for 0, 2'b01 for +1 and 2'b11 for −1, and 2'b10 never appears.
- R10: During reset `mlt_o` is 0, and the phase is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_en_i | input | 1 | Transmit enable, sampled on strobe edges |
| txd_i | input | 4 | Transmit nibble, sampled on strobe edges |
| nib_stb_o | output | 1 | High when the coming edge takes a nibble |
| mlt_o | output | 2 | Signed MLT-3 line level |

## Verification
A nibble taken on a strobe edge affects `mlt_o` no earlier than the next rising edge. Its five bits show up on the five rising edges that follow the load, the last one on the next strobe edge. The bench samples `mlt_o` after each falling edge and credits any level change to the rising edge just before. It removes its own scrambler key to recover the bit, and builds up five bits. On each strobe edge it compares the finished group with the group it predicted when that nibble was driven.

// File: rtl/fe_tx_pkg.sv
package fe_tx_pkg;
  localparam int unsigned NIB_W = 4;
  localparam int unsigned SYM_W = 5;

  typedef enum logic [1:0] {
    FR_IDLE = 2'd0,
    FR_SSD2 = 2'd1,
    FR_DATA = 2'd2,
    FR_ESD2 = 2'd3
  } fr_state_e;

  localparam logic [SYM_W-1:0] SYM_IDLE = 5'b11111;
  localparam logic [SYM_W-1:0] SYM_SSD1 = 5'b11000;
  localparam logic [SYM_W-1:0] SYM_SSD2 = 5'b10001;
  localparam logic [SYM_W-1:0] SYM_ESD1 = 5'b01101;
  localparam logic [SYM_W-1:0] SYM_ESD2 = 5'b00111;

  function automatic logic [SYM_W-1:0] enc_4b5b(input logic [NIB_W-1:0] nib);
    logic [SYM_W-1:0] s;
    case (nib)
      4'h0: s = 5'b11110;
      4'h1: s = 5'b01001;
      4'h2: s = 5'b10100;
      4'h3: s = 5'b10101;
      4'h4: s = 5'b01010;
      4'h5: s = 5'b01011;
      4'h6: s = 5'b01110;
      4'h7: s = 5'b01111;
      4'h8: s = 5'b10010;
      4'h9: s = 5'b10011;
      4'hA: s = 5'b10110;
      4'hB: s = 5'b10111;
      4'hC: s = 5'b11010;
      4'hD: s = 5'b11011;
      4'hE: s = 5'b11100;
      default: s = 5'b11101;
    endcase
    return s;
  endfunction

  // MLT-3 level per phase: 0, +1, 0, -1
  function automatic logic [1:0] mlt_level(input logic [1:0] ph);
    logic [1:0] l;
    case (ph)
      2'd1: l = 2'b01;
      2'd3: l = 2'b11;
      default: l = 2'b00;
    endcase
    return l;
  endfunction
endpackage

// File: rtl/fe_tx_framer.sv
module fe_tx_framer
  import fe_tx_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tx_en_i,
  input  logic [NIB_W-1:0] txd_i,
  output logic             ld_o,
  output logic [SYM_W-1:0] sym_o,
  output fr_state_e        state_o
);
  localparam int unsigned CNT_W = $clog2(SYM_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SYM_W - 1);

  logic [CNT_W-1:0] cnt_q;
  fr_state_e        st_q, st_d;

  assign ld_o    = (cnt_q == '0);
  assign state_o = st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (cnt_q == CNT_LAST) cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

  always_comb begin
    st_d  = st_q;
    sym_o = SYM_IDLE;
    unique case (st_q)
      FR_IDLE: if (tx_en_i) begin
        sym_o = SYM_SSD1;
        st_d  = FR_SSD2;
      end
      FR_SSD2: begin
        sym_o = SYM_SSD2;
        st_d  = FR_DATA;
      end
      FR_DATA: if (tx_en_i) begin
        sym_o = enc_4b5b(txd_i);
      end else begin
        sym_o = SYM_ESD1;
        st_d  = FR_ESD2;
      end
      FR_ESD2: begin
        sym_o = SYM_ESD2;
        st_d  = FR_IDLE;
      end
      default: st_d = FR_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   st_q <= FR_IDLE;
    else if (ld_o) st_q <= st_d;
  end
endmodule

// File: rtl/fe_tx_serializer.sv
module fe_tx_serializer
  import fe_tx_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ld_i,
  input  logic [SYM_W-1:0] sym_i,
  output logic             bit_o
);
  logic [SYM_W-1:0] sh_q;

  assign bit_o = sh_q[SYM_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   sh_q <= SYM_IDLE;
    else if (ld_i) sh_q <= sym_i;
    else           sh_q <= {sh_q[SYM_W-2:0], 1'b0};
  end
endmodule

// File: rtl/fe_tx_scrambler.sv
module fe_tx_scrambler #(
  parameter int unsigned LFSR_W = 11,
  parameter int unsigned TAP    = 9,
  parameter logic [LFSR_W-1:0] SEED = '1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_i,
  output logic bit_o
);
  logic [LFSR_W-1:0] s_q;
  logic              key;

  assign key   = s_q[LFSR_W-1] ^ s_q[TAP-1];
  assign bit_o = bit_i ^ key;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) s_q <= SEED;
    else         s_q <= {s_q[LFSR_W-2:0], key};
  end
endmodule

// File: rtl/fe_tx_line_coder.sv
module fe_tx_line_coder
  import fe_tx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       bit_i,
  output logic       nrzi_o,
  output logic [1:0] mlt_o
);
  logic       nrzi_q;
  logic [1:0] ph_q;

  assign nrzi_o = nrzi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) nrzi_q <= 1'b0;
    else         nrzi_q <= nrzi_q ^ bit_i;
  end

  // one MLT-3 step per NRZI edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= 2'd0;
      mlt_o <= 2'b00;
    end else if (nrzi_q != (nrzi_q ^ bit_i)) begin
      ph_q  <= ph_q + 2'd1;
      mlt_o <= mlt_level(ph_q + 2'd1);
    end
  end
endmodule

// File: rtl/fe_tx_encoder.sv
module fe_tx_encoder
  import fe_tx_pkg::*;
#(
  parameter int unsigned LFSR_W = 11,
  parameter int unsigned LFSR_TAP = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tx_en_i,
  input  logic [NIB_W-1:0] txd_i,
  output logic             nib_stb_o,
  output logic [1:0]       mlt_o
);
  logic             ld;
  logic [SYM_W-1:0] sym;
  fr_state_e        fr_state;
  logic             ser_bit;
  logic             scr_bit;
  logic             nrzi;

  assign nib_stb_o = ld;

  fe_tx_framer u_framer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tx_en_i (tx_en_i),
    .txd_i   (txd_i),
    .ld_o    (ld),
    .sym_o   (sym),
    .state_o (fr_state)
  );

  fe_tx_serializer u_ser (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ld_i   (ld),
    .sym_i  (sym),
    .bit_o  (ser_bit)
  );

  fe_tx_scrambler #(
    .LFSR_W (LFSR_W),
    .TAP    (LFSR_TAP)
  ) u_scr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .bit_i  (ser_bit),
    .bit_o  (scr_bit)
  );

  fe_tx_line_coder u_line (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .bit_i  (scr_bit),
    .nrzi_o (nrzi),
    .mlt_o  (mlt_o)
  );
endmodule

// File: rtl/fe_tx_encoder_chk.sv
module fe_tx_encoder_chk
  import fe_tx_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tx_en_i,
  input logic       nib_stb_o,
  input logic [1:0] mlt_o,
  input logic       nrzi_i,
  input logic       ser_bit_i,
  input fr_state_e  fr_state_i
);
  localparam logic [2:0] GAP_DUE = 3'(SYM_W - 1);
  logic [2:0] gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        gap_q <= GAP_DUE;
    else if (nib_stb_o) gap_q <= '0;
    else                gap_q <= gap_q + 3'd1;
  end

  // R1
  stb_period_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nib_stb_o == (gap_q == GAP_DUE));

  // R9
  mlt_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mlt_o != 2'b10);

  // R9
  mlt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mlt_o != $past(mlt_o)) && ($past(mlt_o) != 2'b00) |-> mlt_o == 2'b00);

  // R8
  nrzi_mlt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nrzi_i != $past(nrzi_i)) == (mlt_o != $past(mlt_o)));

  // R3
  ssd_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nib_stb_o && tx_en_i && fr_state_i == FR_IDLE |=>
      ser_bit_i ##1 ser_bit_i ##1 !ser_bit_i ##1 !ser_bit_i ##1 !ser_bit_i
      ##1 ser_bit_i ##1 !ser_bit_i ##1 !ser_bit_i ##1 !ser_bit_i ##1 ser_bit_i);

  // R4
  esd_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nib_stb_o && !tx_en_i && fr_state_i == FR_DATA |=>
      !ser_bit_i ##1 ser_bit_i ##1 ser_bit_i ##1 !ser_bit_i ##1 ser_bit_i
      ##1 !ser_bit_i ##1 !ser_bit_i ##1 ser_bit_i ##1 ser_bit_i ##1 ser_bit_i);
endmodule

bind fe_tx_encoder fe_tx_encoder_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tx_en_i    (tx_en_i),
  .nib_stb_o  (nib_stb_o),
  .mlt_o      (mlt_o),
  .nrzi_i     (nrzi),
  .ser_bit_i  (ser_bit),
  .fr_state_i (fr_state)
);

// File: tb/fe_tx_encoder_tb.sv
module fe_tx_encoder_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tx_en_i = 1'b0;
  logic [3:0] txd_i = 4'h0;
  logic       nib_stb_o;
  logic [1:0] mlt_o;

  always #10 clk_i = ~clk_i;

  fe_tx_encoder u_dut (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tx_en_i   (tx_en_i),
    .txd_i     (txd_i),
    .nib_stb_o (nib_stb_o),
    .mlt_o     (mlt_o)
  );

  int  n_chk = 0;
  int  n_err = 0;
  bit  done  = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [4:0] code_of(input logic [3:0] n);
    case (n)
      4'h0: return 5'b11110; 4'h1: return 5'b01001;
      4'h2: return 5'b10100; 4'h3: return 5'b10101;
      4'h4: return 5'b01010; 4'h5: return 5'b01011;
      4'h6: return 5'b01110; 4'h7: return 5'b01111;
      4'h8: return 5'b10010; 4'h9: return 5'b10011;
      4'hA: return 5'b10110; 4'hB: return 5'b10111;
      4'hC: return 5'b11010; 4'hD: return 5'b11011;
      4'hE: return 5'b11100; default: return 5'b11101;
    endcase
  endfunction

  // stimulus, one entry per strobe
  bit         s_en[$];
  logic [3:0] s_d[$];
  task automatic add(input bit en, input logic [3:0] d);
    s_en.push_back(en);
    s_d.push_back(d);
  endtask

  // expected: {is_data, nibble, group, tag}
  typedef struct { bit is_data; logic [3:0] nib; logic [4:0] sym; string req; } exp_t;
  exp_t eq[$];

  logic [10:0] lfsr = '1;
  logic [1:0]  ph = 2'd0;
  logic [1:0]  prev_mlt = 2'b00;
  logic [4:0]  acc = '0;
  bit          last_stb = 1'b0;
  bit          seen_load = 1'b0;
  int          bst = 0;
  int          si = 0;

  function automatic logic [1:0] lvl(input logic [1:0] p);
    return (p == 2'd1) ? 2'b01 : (p == 2'd3) ? 2'b11 : 2'b00;
  endfunction

  task automatic drive_if_stb();
    bit en; logic [3:0] d; exp_t e;
    last_stb = nib_stb_o;
    if (!nib_stb_o) return;
    en = 1'b0; d = 4'h0;
    if (si < s_en.size()) begin en = s_en[si]; d = s_d[si]; si++; end
    tx_en_i = en; txd_i = d;
    e.is_data = 1'b0; e.nib = d;
    case (bst)
      0: if (en) begin e.sym = 5'b11000; e.req = "R3"; bst = 1; end
         else begin e.sym = 5'b11111; e.req = "R5"; end
      1: begin e.sym = 5'b10001; e.req = "R3"; bst = 2; end
      2: if (en) begin e.sym = code_of(d); e.is_data = 1'b1; e.req = "R2"; end
         else begin e.sym = 5'b01101; e.req = "R4"; bst = 3; end
      default: begin e.sym = 5'b00111; e.req = "R4"; bst = 0; end
    endcase
    eq.push_back(e);
  endtask

  task automatic step();
    logic k; logic b; bit chg; exp_t e; int hit;
    @(posedge clk_i);
    @(negedge clk_i);
    chg = (mlt_o != prev_mlt);
    if (chg) begin
      ph = ph + 2'd1;
      chk(mlt_o == lvl(ph), "R9", mlt_o, lvl(ph));
    end
    prev_mlt = mlt_o;
    k = lfsr[10] ^ lfsr[8];
    lfsr = {lfsr[9:0], k};
    b = chg ^ k;                                  // R7 descramble, R8 NRZI
    acc = {acc[3:0], b};
    if (last_stb) begin
      if (seen_load && eq.size() > 0) begin
        e = eq.pop_front();
        chk(acc == e.sym, {e.req, "/R6"}, acc, e.sym);
        if (e.is_data) begin
          hit = -1;
          for (int n = 0; n < 16; n++) if (code_of(4'(n)) == acc) hit = n;
          chk(hit == int'(e.nib), "R2 nibble", hit, e.nib);
        end
      end
      seen_load = 1'b1;
    end
    drive_if_stb();
  endtask

  initial begin
    // idle lead-in
    for (int i = 0; i < 3; i++) add(1'b0, 4'h0);
    // frame with every nibble value
    add(1'b1, 4'h5); add(1'b1, 4'h5);
    for (int n = 0; n < 16; n++) add(1'b1, 4'(n));
    add(1'b0, 4'h0); add(1'b0, 4'h0); add(1'b0, 4'h0);
    // short frame, then enable high during the second end group (ignored)
    add(1'b1, 4'h5); add(1'b1, 4'h5); add(1'b1, 4'hA);
    add(1'b0, 4'h0); add(1'b1, 4'h5);
    // back-to-back frame
    add(1'b1, 4'h5); add(1'b1, 4'h5); add(1'b1, 4'h3); add(1'b1, 4'hC);
    add(1'b0, 4'h7); add(1'b0, 4'h0);
    // one-nibble enable pulse: start pair still completes
    add(1'b1, 4'h9); add(1'b0, 4'h9); add(1'b0, 4'h0); add(1'b0, 4'h0);
    for (int i = 0; i < 4; i++) add(1'b0, 4'h0);

    #35;
    // R10 reset state
    chk(mlt_o == 2'b00, "R10 level", mlt_o, 0);
    chk(nib_stb_o == 1'b1, "R1 strobe at reset", nib_stb_o, 1);
    @(negedge clk_i);
    rst_ni = 1'b1;
    drive_if_stb();
    for (int c = 0; c < 5 * (s_en.size() + 3); c++) begin
      step();
      if (c < 10) chk(nib_stb_o == ((c % 5) == 4), "R1 strobe", nib_stb_o, (c % 5) == 4);
    end
    chk(si == s_en.size(), "R1 consumed", si, s_en.size());
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_err, n_chk);
      $finish;
    end
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_err++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_err, n_chk);
      $finish;
    end
  end
endmodule